// File: doc/BRIEF.md
# Host Command Mailbox with Busy and Error Status

This block sits between a host register bus and an internal command controller. The host places up to two argument words in the two data registers and then writes a command identifier to the control/status register. That single write launches the command. The controller receives a one-cycle start pulse together with the identifier and both arguments. All three values stay fixed while the command runs.

While the command runs, the status register shows a busy flag. The host may poll this flag before it issues a new command. The controller reports completion with a valid strobe, an error flag and two result words. The mailbox then drops busy and records the error flag. On success it loads both result words into the data registers. On failure it writes the error code into the first data register and leaves the second one alone. The meaning of each command belongs to the controller, not to this block.

Top module: `cmd_mailbox`

## Requirements
- R1: While not busy, a host write to address 1 loads word A (DATA0) and a write to address 2 loads word B (DATA1). Each word reads back at the same address in the cycle after the write edge.
- R2: While not busy, a host write to address 0 starts a command. From the next cycle the status word reads with busy in bit 31 and with the written ID (write data bits [7:0]) in bits [7:0].
- R3: `cmdStart` is high for exactly one cycle, in the cycle after the launching write edge.
- R4: `cmdId`, `cmdArg0` and `cmdArg1` are valid from the start pulse and do not change while busy is set.
- R5: `doneValid` while busy clears busy in the next cycle and copies `doneErr` into status bit 30.
- R6: On a completion with `doneErr` high, DATA0 takes `doneWord0` as the error code and DATA1 keeps its previous value.
- R7: On a completion with `doneErr` low, DATA0 takes `doneWord0` and DATA1 takes `doneWord1`.
- R8: While busy, host writes to any address are ignored. DATA0, DATA1, the ID and the busy state are unchanged.
- R9: Launching a new command clears the error bit.
- R10: `doneValid` while not busy has no effect on status or data.
- R11: After reset, busy, error, the ID and both data words read as zero and `cmdStart` is low. Address 3 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Host write strobe |
| busAddr | input | 2 | Host register address (0 control/status, 1 DATA0, 2 DATA1) |
| busWrData | input | 32 | Host write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| cmdStart | output | 1 | One-cycle command launch pulse |
| cmdId | output | 8 | Identifier of the current command |
| cmdArg0 | output | 32 | First argument (DATA0) |
| cmdArg1 | output | 32 | Second argument (DATA1) |
| doneValid | input | 1 | Controller completion strobe |
| doneErr | input | 1 | Completion failed |
| doneWord0 | input | 32 | Result word or error code |
| doneWord1 | input | 32 | Second result word |

## Verification
Each accepted host write and each accepted completion takes effect at the clock edge that samples it. The new values appear on `busRdData` and on the command outputs in the cycle that follows that edge, so each result is due one cycle after its stimulus. The start pulse shows only in that one cycle. The bench drives inputs just after the falling edge. A behavioural model updates on each rising edge, and the bench compares every output against the model at the next falling edge, which is the first sampling point after the edge that caused the change. Directed reads of known values are taken in the same half-cycle window.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ARG_A = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ARG_B = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic wrArgA;
    logic wrArgB;
    logic launch;
    logic capture;
    logic captureErr;
  } mbx_strobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              doneValid,
  input  logic              doneErr,
  output mbx_strobe_t       stb,
  output logic              busy,
  output logic              err,
  output logic              cmdStart
);
  logic busyQ, errQ, startQ;
  logic hostIdleWr;

  always_comb begin
    hostIdleWr     = busWrEn && !busyQ;
    stb.wrArgA     = hostIdleWr && (busAddr == ADDR_ARG_A);
    stb.wrArgB     = hostIdleWr && (busAddr == ADDR_ARG_B);
    stb.launch     = hostIdleWr && (busAddr == ADDR_CTRL);
    stb.capture    = busyQ && doneValid;
    stb.captureErr = doneErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      errQ   <= 1'b0;
      startQ <= 1'b0;
    end else begin
      startQ <= stb.launch;
      if (stb.launch) begin
        busyQ <= 1'b1;
        errQ  <= 1'b0;
      end else if (stb.capture) begin
        busyQ <= 1'b0;
        errQ  <= doneErr;
      end
    end
  end

  assign busy     = busyQ;
  assign err      = errQ;
  assign cmdStart = startQ;
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbx_strobe_t       stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] doneWord0,
  input  logic [DATA_W-1:0] doneWord1,
  input  logic              busy,
  input  logic              err,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] data0,
  output logic [DATA_W-1:0] data1,
  output logic [ID_W-1:0]   cmdId
);
  localparam int PAD_W = DATA_W - 2 - ID_W;

  logic [DATA_W-1:0] data0Q, data1Q;
  logic [ID_W-1:0]   idQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      data0Q <= '0;
      data1Q <= '0;
      idQ    <= '0;
    end else begin
      if (stb.wrArgA)  data0Q <= busWrData;
      if (stb.wrArgB)  data1Q <= busWrData;
      if (stb.launch)  idQ    <= busWrData[ID_W-1:0];
      if (stb.capture) begin
        data0Q <= doneWord0;
        if (!stb.captureErr) data1Q <= doneWord1;
      end
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_CTRL:  busRdData = {busy, err, {PAD_W{1'b0}}, idQ};
      ADDR_ARG_A: busRdData = data0Q;
      ADDR_ARG_B: busRdData = data1Q;
      default:    busRdData = '0;
    endcase
  end

  assign data0 = data0Q;
  assign data1 = data1Q;
  assign cmdId = idQ;
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              cmdStart,
  output logic [ID_W-1:0]   cmdId,
  output logic [DATA_W-1:0] cmdArg0,
  output logic [DATA_W-1:0] cmdArg1,
  input  logic              doneValid,
  input  logic              doneErr,
  input  logic [DATA_W-1:0] doneWord0,
  input  logic [DATA_W-1:0] doneWord1
);
  mbx_strobe_t stb;
  logic        busy;
  logic        err;

  mbx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .doneValid (doneValid),
    .doneErr   (doneErr),
    .stb       (stb),
    .busy      (busy),
    .err       (err),
    .cmdStart  (cmdStart)
  );

  mbx_datapath #(.DATA_W(DATA_W), .ID_W(ID_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .doneWord0 (doneWord0),
    .doneWord1 (doneWord1),
    .busy      (busy),
    .err       (err),
    .busRdData (busRdData),
    .data0     (cmdArg0),
    .data1     (cmdArg1),
    .cmdId     (cmdId)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              doneValid,
  input logic              cmdStart,
  input logic [ID_W-1:0]   cmdId,
  input logic [DATA_W-1:0] cmdArg0,
  input logic [DATA_W-1:0] cmdArg1,
  input logic              busy,
  input logic              err
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart); // R3

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> busy); // R2

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(cmdId) && $stable(cmdArg0) && $stable(cmdArg1))); // R4

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && doneValid) |=> !busy); // R5

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busWrEn && !doneValid) |=> (busy && !cmdStart && $stable(cmdId) && $stable(cmdArg0))); // R8

  AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> !err); // R9

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && doneValid && !busWrEn) |=> (!busy && $stable(err) && $stable(cmdArg0) && $stable(cmdArg1))); // R10
endmodule

bind cmd_mailbox mbx_checker #(.DATA_W(DATA_W), .ID_W(ID_W)) u_mbxChk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .doneValid (doneValid),
  .cmdStart  (cmdStart),
  .cmdId     (cmdId),
  .cmdArg0   (cmdArg0),
  .cmdArg1   (cmdArg1),
  .busy      (busy),
  .err       (err)
);

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        cmdStart;
  logic [7:0]  cmdId;
  logic [31:0] cmdArg0, cmdArg1;
  logic        doneValid = 1'b0;
  logic        doneErr = 1'b0;
  logic [31:0] doneWord0 = '0, doneWord1 = '0;

  int vectors = 0;
  int misses = 0;
  bit chkOn = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  bit          mBusy = 0, mErr = 0, mStart = 0;
  logic [7:0]  mId = '0;
  logic [31:0] mD0 = '0, mD1 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_mailbox u_cmd_mailbox (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .cmdStart(cmdStart),
    .cmdId(cmdId), .cmdArg0(cmdArg0), .cmdArg1(cmdArg1),
    .doneValid(doneValid), .doneErr(doneErr),
    .doneWord0(doneWord0), .doneWord1(doneWord1)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] modelRead(logic [1:0] a);
    case (a)
      2'd0:    return {mBusy, mErr, 22'd0, mId};
      2'd1:    return mD0;
      2'd2:    return mD1;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mErr = 0; mStart = 0; mId = '0; mD0 = '0; mD1 = '0;
    end else begin
      mStart = 0;
      if (mBusy && doneValid) begin
        mBusy = 0;
        mErr  = doneErr;
        mD0   = doneWord0;
        if (!doneErr) mD1 = doneWord1;
      end else if (!mBusy && busWrEn) begin
        if (busAddr == 2'd0) begin
          mBusy = 1; mErr = 0; mStart = 1; mId = busWrData[7:0];
        end else if (busAddr == 2'd1) mD0 = busWrData;
        else if (busAddr == 2'd2) mD1 = busWrData;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (chkOn) begin
      chk("R3 cmdStart", {31'd0, cmdStart}, {31'd0, mStart});
      if (mBusy) begin
        chk("R4 cmdId", {24'd0, cmdId}, {24'd0, mId});
        chk("R4 cmdArg0", cmdArg0, mD0);
        chk("R4 cmdArg1", cmdArg1, mD1);
      end
      chk("R5 busRdData", busRdData, modelRead(busAddr));
    end
  end

  task automatic idleIns();
    busWrEn = 0; doneValid = 0; doneErr = 0;
  endtask

  task automatic hostWrite(logic [1:0] a, logic [31:0] d);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk); #1;
    idleIns();
  endtask

  task automatic complete(bit e, logic [31:0] w0, logic [31:0] w1);
    doneValid = 1; doneErr = e; doneWord0 = w0; doneWord1 = w1;
    @(negedge clk); #1;
    idleIns();
  endtask

  task automatic peek(string tag, logic [1:0] a, logic [31:0] exp);
    idleIns();
    busAddr = a;
    #1;
    chk(tag, busRdData, exp);
    @(negedge clk); #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk("R11 cmdStart", {31'd0, cmdStart}, 32'd0);
    peek("R11 status", 2'd0, 32'h0);
    rstN = 1;
    chkOn = 1;
    peek("R11 data0", 2'd1, 32'h0);
    peek("R11 addr3", 2'd3, 32'h0);

    hostWrite(2'd1, 32'hA1A1_0001);
    hostWrite(2'd2, 32'hB2B2_0002);
    peek("R1 data0", 2'd1, 32'hA1A1_0001);
    peek("R1 data1", 2'd2, 32'hB2B2_0002);

    busAddr = 2'd0;
    hostWrite(2'd0, 32'h0000_0115);
    chk("R3 start pulse", {31'd0, cmdStart}, 32'd1);
    chk("R3 id", {24'd0, cmdId}, 32'h15);
    peek("R2 status busy", 2'd0, 32'h8000_0015);
    chk("R3 pulse ended", {31'd0, cmdStart}, 32'd0);

    hostWrite(2'd1, 32'hDEAD_BEEF);
    hostWrite(2'd0, 32'h0000_0033);
    peek("R8 data0 kept", 2'd1, 32'hA1A1_0001);
    peek("R8 status kept", 2'd0, 32'h8000_0015);

    complete(1'b0, 32'h0000_0111, 32'h0000_0222);
    peek("R7 status done", 2'd0, 32'h0000_0015);
    peek("R7 data0 result", 2'd1, 32'h0000_0111);
    peek("R7 data1 result", 2'd2, 32'h0000_0222);

    hostWrite(2'd0, 32'h0000_0007);
    complete(1'b1, 32'h0000_00E5, 32'h0000_0999);
    peek("R6 status err", 2'd0, 32'h4000_0007);
    peek("R6 data0 code", 2'd1, 32'h0000_00E5);
    peek("R6 data1 kept", 2'd2, 32'h0000_0222);

    complete(1'b0, 32'h1234_5678, 32'h8765_4321);
    peek("R10 status", 2'd0, 32'h4000_0007);
    peek("R10 data0", 2'd1, 32'h0000_00E5);

    hostWrite(2'd0, 32'h0000_0008);
    peek("R9 err cleared", 2'd0, 32'h8000_0008);
    complete(1'b0, 32'h5, 32'h6);

    // launch and complete back to back, then mixed traffic
    for (int i = 0; i < 24; i++) begin
      hostWrite(2'd1, 32'h1000_0000 + i);
      hostWrite(2'd2, 32'h2000_0000 ^ (i * 7));
      busAddr = 2'(i % 3);
      hostWrite(2'd0, 32'(i + 8'h40));
      for (int k = 0; k < (i % 4); k++) begin
        if (k == 1) hostWrite(2'(k), 32'hFFFF_0000 + k);
        else begin @(negedge clk); #1; end
      end
      complete(i[0], 32'h3000_0000 + i, 32'h4000_0000 + i);
      peek("R7 loop data1", 2'd2, mD1);
    end
    repeat (3) @(negedge clk);
    finish();
  end
endmodule